// File: doc/BRIEF.md
# 128-bit Block Word Serializer

This block joins a 32-bit register bus to a 128-bit cipher datapath. On the write side it collects four successive 32-bit words into one 128-bit block. The first word goes into the top of the block. It offers the finished block to the core through a valid/ready handshake. On the read side it takes the 128-bit result of the core and returns it as four successive 32-bit words, top word first. The read side answers only once the core reports that its computation is complete.

Each word passes through a swap stage in both directions. A 2-bit data-type input picks the swap, and the block samples it on the same cycle as the write or read strobe. A low enable input returns both word counters to the start of a block. It also withdraws a pending block and clears the error flag. The buffered data itself is kept.

Top module: `blk_word_serdes`

## Requirements
- R1: Four accepted write strobes form one block. Word k (k = 0 first) lands in bits [127-32k -: 32] of `in_blk`. `in_valid` goes high on the clock edge that takes the fourth word.
- R2: The swap applies within each 32-bit word. `dtype` 00 passes the word unchanged. 01 exchanges the two 16-bit halves. 10 reverses the byte order. 11 reverses the bit order. Written words are swapped before they are stored.
- R3: Once `in_valid` is high, it stays high until a cycle in which `in_ready` is high, and `in_blk` holds its value during that time. `in_valid` is low on the cycle after the handshake.
- R4: A write strobe while `in_valid` is high leaves `in_blk` unchanged and sets `wr_err` on the next edge. `wr_err` stays set until enable goes low.
- R5: When `done` is high, each read strobe returns the next word of `out_blk`, from [127:96] down to [31:0], after the swap selected by `dtype`. The result is on `rd_data` one cycle after the strobe.
- R6: A read strobe while `done` is low returns zero and does not advance the read position.
- R7: While enable is low, both word positions return to zero, `in_valid` and `wr_err` are cleared, and strobes have no effect. Reset gives the same state with `rd_data` at zero.
- R8: Both word positions wrap to zero after the fourth word. A fifth read returns bits [127:96] again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; low returns the block to its start state |
| dtype | input | 2 | Swap select for the current word |
| wr_stb | input | 1 | Write strobe for one input word |
| wr_data | input | 32 | Input word |
| rd_stb | input | 1 | Read strobe for one output word |
| rd_data | output | 32 | Output word, registered |
| in_blk | output | 128 | Assembled input block |
| in_valid | output | 1 | Input block offered to the core |
| in_ready | input | 1 | Core accepts the input block |
| out_blk | input | 128 | Result block from the core |
| done | input | 1 | Core computation complete |
| wr_err | output | 1 | Write seen while a block was pending |

## Verification
If the write position is wrong, words land in the wrong slice of `in_blk`, or `in_valid` rises at the wrong count. Either shows on the cycle after the fourth strobe. A wrong read position or a wrong swap shows on `rd_data` one cycle after the faulty strobe. An unwanted advance while `done` is low shows on the first good read that follows, because that read returns a word other than the top one. A counter that survives disable shows when the next block is assembled. A pending block that survives disable shows as `in_valid` still high one cycle later.

// File: rtl/blk_word_serdes.sv
module blk_word_serdes #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     enable,
  input  logic [1:0]               dtype,
  input  logic                     wr_stb,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic                     rd_stb,
  output logic [WORD_W-1:0]        rd_data,
  output logic [WORD_W*WORDS-1:0]  in_blk,
  output logic                     in_valid,
  input  logic                     in_ready,
  input  logic [WORD_W*WORDS-1:0]  out_blk,
  input  logic                     done,
  output logic                     wr_err
);
  localparam int BLK_W = WORD_W * WORDS;
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  logic [CNT_W-1:0]  in_cnt, out_cnt;
  logic [WORD_W-1:0] out_word;

  function automatic logic [WORD_W-1:0] swz(input logic [WORD_W-1:0] w, input logic [1:0] t);
    logic [WORD_W-1:0] r;
    r = w;
    case (t)
      2'b01: r = {w[WORD_W/2-1:0], w[WORD_W-1:WORD_W/2]};
      2'b10: for (int b = 0; b < WORD_W/8; b++) r[8*b +: 8] = w[WORD_W-8-8*b +: 8];
      2'b11: for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
      default: r = w;
    endcase
    return r;
  endfunction

  wire wr_take = enable && wr_stb && !in_valid;
  wire rd_take = enable && rd_stb && done;

  always_comb begin
    out_word = '0;
    for (int k = 0; k < WORDS; k++)
      if (out_cnt == CNT_W'(k)) out_word = out_blk[BLK_W-1-k*WORD_W -: WORD_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cnt   <= '0;
      in_blk   <= '0;
      in_valid <= 1'b0;
      wr_err   <= 1'b0;
    end else if (!enable) begin
      in_cnt   <= '0;
      in_valid <= 1'b0;
      wr_err   <= 1'b0;
    end else begin
      if (in_valid && in_ready) in_valid <= 1'b0;
      if (wr_stb && in_valid) wr_err <= 1'b1;
      if (wr_take) begin
        for (int k = 0; k < WORDS; k++)
          if (in_cnt == CNT_W'(k)) in_blk[BLK_W-1-k*WORD_W -: WORD_W] <= swz(wr_data, dtype);
        in_cnt <= (in_cnt == LAST) ? '0 : in_cnt + 1'b1;
        if (in_cnt == LAST) in_valid <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_cnt <= '0;
      rd_data <= '0;
    end else if (!enable) begin
      out_cnt <= '0;
    end else if (rd_stb) begin
      rd_data <= done ? swz(out_word, dtype) : '0;
      if (rd_take) out_cnt <= (out_cnt == LAST) ? '0 : out_cnt + 1'b1;
    end
  end
endmodule

module blk_word_serdes_chk #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    enable,
  input logic                    wr_stb,
  input logic                    rd_stb,
  input logic [WORD_W-1:0]       rd_data,
  input logic [WORD_W*WORDS-1:0] in_blk,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    done,
  input logic                    wr_err
);
  // R3
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable && in_valid && !in_ready |=> in_valid);
  // R3
  blk_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable && in_valid && !in_ready |=> $stable(in_blk));
  // R4
  late_write_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    enable && wr_stb && in_valid |=> wr_err);
  // R6
  early_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !done |=> rd_data == '0);
  // R7
  disable_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !in_valid && !wr_err);
  // R1
  valid_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_valid) |-> $past(wr_stb));
endmodule

bind blk_word_serdes blk_word_serdes_chk #(.WORD_W(WORD_W), .WORDS(WORDS)) i_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .wr_stb(wr_stb), .rd_stb(rd_stb),
  .rd_data(rd_data), .in_blk(in_blk), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .wr_err(wr_err));

// File: tb/test_blk_word_serdes.sv
module test_blk_word_serdes;
  localparam int CLK_P = 10;

  logic         clk = 0, rst_n = 0, enable = 0;
  logic [1:0]   dtype = 0;
  logic         wr_stb = 0, rd_stb = 0, in_ready = 0, done = 0;
  logic [31:0]  wr_data = 0;
  logic [31:0]  rd_data;
  logic [127:0] in_blk, out_blk = 0;
  logic         in_valid, wr_err;
  int total = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  blk_word_serdes i_blk_word_serdes (
    .clk(clk), .rst_n(rst_n), .enable(enable), .dtype(dtype),
    .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
    .in_blk(in_blk), .in_valid(in_valid), .in_ready(in_ready),
    .out_blk(out_blk), .done(done), .wr_err(wr_err));

  function automatic logic [31:0] swp(input logic [31:0] w, input logic [1:0] t);
    logic [31:0] r;
    case (t)
      2'b00: r = w;
      2'b01: r = {w[15:0], w[31:16]};
      2'b10: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
      default: for (int i = 0; i < 32; i++) r[i] = w[31-i];
    endcase
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d, input logic [1:0] t);
    @(negedge clk); wr_stb = 1; wr_data = d; dtype = t;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic rd(input logic [1:0] t, output logic [31:0] v);
    @(negedge clk); rd_stb = 1; dtype = t;
    @(negedge clk); rd_stb = 0; v = rd_data;
  endtask

  task automatic accept();
    @(negedge clk); in_ready = 1;
    @(negedge clk); in_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    logic [127:0] exp;
    logic [1:0] t;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R7 reset state
    chk("R7", {in_valid, wr_err}, 0);
    chk("R7", rd_data, 0);
    enable = 1;

    // R6 read before done
    out_blk = 128'h00112233_44556677_8899aabb_ccddeeff;
    rd(2'b00, v); chk("R6", v, 0);
    done = 1;
    rd(2'b00, v); chk("R6", v, 32'h00112233);
    // R5 remaining words with each swap
    rd(2'b01, v); chk("R5", v, 32'h66774455);
    rd(2'b10, v); chk("R5", v, 32'hbbaa9988);
    rd(2'b11, v); chk("R5", v, swp(32'hccddeeff, 2'b11));
    // R8 wrap
    rd(2'b00, v); chk("R8", v, 32'h00112233);

    // R7 disable restarts reading
    @(negedge clk); enable = 0;
    @(negedge clk); enable = 1;
    rd(2'b00, v); chk("R7", v, 32'h00112233);
    @(negedge clk); enable = 0;
    @(negedge clk); enable = 1;

    // R2 directed swaps, R1 placement
    wr(32'h12345678, 2'b00);
    wr(32'h12345678, 2'b01);
    wr(32'h12345678, 2'b10);
    wr(32'h80000001, 2'b11);
    chk("R2", in_blk, 128'h12345678_56781234_78563412_80000001);
    chk("R1", in_valid, 1);

    // R4 write while pending
    exp = in_blk;
    wr(32'hdeadbeef, 2'b00);
    chk("R4", wr_err, 1);
    chk("R4", in_blk, exp);
    chk("R3", in_valid, 1);
    accept();
    chk("R3", in_valid, 0);
    chk("R4", wr_err, 1);
    @(negedge clk); enable = 0;
    @(negedge clk); enable = 1;
    chk("R7", wr_err, 0);

    // R7 disable mid-block, writes while disabled ignored
    wr(32'hffffffff, 2'b00);
    wr(32'heeeeeeee, 2'b00);
    @(negedge clk); enable = 0;
    wr(32'h55555555, 2'b00);
    @(negedge clk); enable = 1;
    wr(32'h00000001, 2'b00);
    wr(32'h00000002, 2'b00);
    chk("R7", in_valid, 0);
    wr(32'h00000003, 2'b00);
    chk("R1", in_valid, 0);
    wr(32'h00000004, 2'b00);
    chk("R7", in_blk, 128'h00000001_00000002_00000003_00000004);
    chk("R1", in_valid, 1);
    accept();

    // R1 R2 random blocks
    for (int n = 0; n < 20; n++) begin
      for (int k = 0; k < 4; k++) begin
        w = $urandom; t = 2'($urandom);
        exp[127-32*k -: 32] = swp(w, t);
        wr(w, t);
        if (k < 3) chk("R1", in_valid, 0);
      end
      chk("R1", in_blk, exp);
      chk("R1", in_valid, 1);
      repeat (n % 3) @(negedge clk);
      chk("R3", in_valid, 1);
      accept();
      chk("R3", in_valid, 0);
    end

    // R5 random reads, with occasional early reads (R6)
    for (int n = 0; n < 20; n++) begin
      out_blk = {$urandom, $urandom, $urandom, $urandom};
      done = 0;
      if (n % 4 == 0) begin rd(2'b11, v); chk("R6", v, 0); end
      done = 1;
      for (int k = 0; k < 4; k++) begin
        t = 2'($urandom);
        rd(t, v);
        chk("R5", v, swp(out_blk[127-32*k -: 32], t));
      end
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule